// File: doc/BRIEF.md
# Peripheral Status Responder on an SPI Target Port

This block sits on the target side of an SPI link and answers one-byte requests from a host controller by streaming back front-panel state: a packed switch byte, a bank of potentiometer readings, a bank of encoder counts, and three-byte note packets taken from a FIFO. Each request byte that arrives while nothing is pending is decoded. The first reply byte is placed into the transmit shifter at once, so it appears on MISO during the next byte transfer. Any further reply bytes follow one per transfer until a remaining-byte counter reaches zero.

The SPI pins are oversampled by the system clock through synchronizers. SCLK must therefore run well below the system clock; a half period of at least six system clocks is assumed. The host keeps clocking dummy bytes to collect a reply. Bytes received while a reply is still being counted out are dropped. The byte clocked in alongside the final reply byte is decoded as the next request. Raising chip select at any time discards a partly received byte and cancels the reply.

Top module: `spi_status_responder`

## Requirements
- R1: The port uses SPI mode 0, MSB first. MOSI is sampled on SCLK rising edges and MISO changes after falling edges. The first byte returned after chip select goes low is 0x00.
- R2: While chip select is high, `spi_miso_oe` is low and `spi_miso` is released to high impedance. While chip select is low, `spi_miso_oe` is high.
- R3: Request 0x01 returns `sw_status` as the next byte, and the reply is only that one byte.
- R4: Request 0x02 returns the POT_N potentiometer entries in the next POT_N bytes, entry 0 first. Entry i occupies bits [8i+7:8i] of `pot_vals`.
- R5: Request 0x03 returns the ENC_N encoder entries in the next ENC_N bytes, entry 0 first. Entry i occupies bits [8i+7:8i] of `enc_vals`.
- R6: Request 0x04 with the FIFO not empty pops one packet and returns three bytes: status, then note, then velocity. These are `fifo_data` bits [23:16], [15:8] and [7:0].
- R7: Request 0x04 with `fifo_empty` high returns a single 0x00 and does not pop.
- R8: Any other request value returns a single 0x00.
- R9: Bytes received while reply bytes remain to be loaded are not decoded. The byte received while the final reply byte shifts out is decoded as a request.
- R10: Raising chip select discards a partly received byte and cancels a reply in progress. After chip select goes low again, the next byte returned is 0x00 and the next complete byte is decoded as a request.
- R11: `fifo_pop` is a pulse one system clock wide, issued once per packet taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high impedance when deselected |
| spi_miso_oe | output | 1 | High while MISO is driven |
| sw_status | input | 8 | Packed switch status byte |
| pot_vals | input | 8*POT_N | Potentiometer readings, entry i at bits [8i+7:8i] |
| enc_vals | input | 8*ENC_N | Encoder counts, entry i at bits [8i+7:8i] |
| fifo_empty | input | 1 | Note FIFO has no packet |
| fifo_data | input | 24 | Head packet of the note FIFO: status, note, velocity |
| fifo_pop | output | 1 | Removes the head packet from the note FIFO |

## Verification
A corrupt remaining-byte counter or source selector shows up at MISO within one byte time. The reply then runs too short or too long, or switches source, so the next byte the host collects differs from the expected stream. Filler bytes are chosen so that a filler wrongly decoded as a request changes the very next byte returned. A bit counter left misaligned after a chip-select abort garbles the first full byte of the next transaction. Popping the FIFO wrongly changes the packet returned by the following note request, and the count of pops observed at the port shows it too.

// File: rtl/spi_resp_pkg.sv
// Shared constants and types for the SPI status responder.
package spi_resp_pkg;
    localparam int DW = 8;

    localparam logic [7:0] CMD_SWITCH = 8'h01;
    localparam logic [7:0] CMD_POTS   = 8'h02;
    localparam logic [7:0] CMD_ENCS   = 8'h03;
    localparam logic [7:0] CMD_NOTE   = 8'h04;

    // Which source feeds the remaining bytes of a multi-byte reply.
    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_POT,
        SRC_ENC,
        SRC_NOTE
    } reply_src_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings SCLK, chip select and MOSI into the clk domain and reports
// SCLK edges as one-cycle strobes.
// Assumes: SCLK half period of several clk cycles; STAGES >= 2.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sclk_q;
    logic [TOP:0] csn_q;
    logic [TOP:0] mosi_q;
    logic         sclk_last;

    // Synchronizer chains plus a delayed SCLK copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= '0;
            csn_q     <= '1;
            mosi_q    <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_q    <= {sclk_q[TOP-1:0], sclk};
            csn_q     <= {csn_q[TOP-1:0], cs_n};
            mosi_q    <= {mosi_q[TOP-1:0], mosi};
            sclk_last <= sclk_q[TOP];
        end
    end

    assign sclk_rise = sclk_q[TOP] & ~sclk_last;
    assign sclk_fall = ~sclk_q[TOP] & sclk_last;
    assign cs_act    = ~csn_q[TOP];
    assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/spi_byte_shifter.sv
// Mode-0 shifter: collects MOSI bits on rising edges and advances the
// transmit byte on falling edges. A byte loaded at a byte boundary is
// held until the next transfer starts.
// Assumes: load_en arrives only between a byte's last rising edge and
// the following falling edge.
module spi_byte_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          mosi_s,
    input  logic          load_en,
    input  logic [DW-1:0] load_byte,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          miso_bit
);
    localparam int BW = $clog2(DW);

    logic [BW-1:0] bit_cnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;

    // Bit counting, receive assembly and transmit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else if (!cs_act) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                rx_sh <= {rx_sh[DW-2:0], mosi_s};
                if (bit_cnt == BW'(DW - 1)) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh[DW-2:0], mosi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (sclk_fall && bit_cnt != '0) begin
                tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
            if (load_en) begin
                tx_sh <= load_byte;
            end
        end
    end

    assign miso_bit = tx_sh[DW-1];
endmodule

// File: rtl/spi_reply_seq.sv
// Decodes request bytes and chooses the byte to transmit after each
// completed transfer. It counts down multi-byte replies and pops the
// note FIFO.
// Assumes: fifo_data shows the head packet whenever fifo_empty is low.
module spi_reply_seq
    import spi_resp_pkg::*;
#(
    parameter int POT_N = 8,
    parameter int ENC_N = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_act,
    input  logic                byte_done,
    input  logic [DW-1:0]       rx_byte,
    input  logic [DW-1:0]       sw_status,
    input  logic [POT_N*DW-1:0] pot_vals,
    input  logic [ENC_N*DW-1:0] enc_vals,
    input  logic                fifo_empty,
    input  logic [3*DW-1:0]     fifo_data,
    output logic                load_en,
    output logic [DW-1:0]       load_byte,
    output logic                fifo_pop
);
    localparam int MAXN = (ENC_N > POT_N) ? ENC_N : POT_N;
    localparam int CW   = $clog2(MAXN + 1);

    reply_src_e         src_q;
    logic [CW-1:0]      rem_q;
    logic [CW-1:0]      idx_q;
    logic [2*DW-1:0]    pkt_q;

    // Per-byte choice: continue the active reply or decode a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= SRC_IDLE;
            rem_q     <= '0;
            idx_q     <= '0;
            pkt_q     <= '0;
            load_en   <= 1'b0;
            load_byte <= '0;
            fifo_pop  <= 1'b0;
        end else begin
            load_en  <= 1'b0;
            fifo_pop <= 1'b0;
            if (!cs_act) begin
                src_q <= SRC_IDLE;
                rem_q <= '0;
                idx_q <= '0;
            end else if (byte_done) begin
                load_en <= 1'b1;
                if (rem_q != '0) begin
                    rem_q <= rem_q - 1'b1;
                    idx_q <= idx_q + 1'b1;
                    case (src_q)
                        SRC_POT:  load_byte <= pot_vals[int'(idx_q)*DW +: DW];
                        SRC_ENC:  load_byte <= enc_vals[int'(idx_q)*DW +: DW];
                        SRC_NOTE: load_byte <= (rem_q == CW'(2)) ? pkt_q[2*DW-1:DW]
                                                                 : pkt_q[DW-1:0];
                        default:  load_byte <= '0;
                    endcase
                end else begin
                    idx_q <= CW'(1);
                    src_q <= SRC_IDLE;
                    case (rx_byte)
                        CMD_SWITCH: load_byte <= sw_status;
                        CMD_POTS: begin
                            load_byte <= pot_vals[DW-1:0];
                            rem_q     <= CW'(POT_N - 1);
                            src_q     <= SRC_POT;
                        end
                        CMD_ENCS: begin
                            load_byte <= enc_vals[DW-1:0];
                            rem_q     <= CW'(ENC_N - 1);
                            src_q     <= SRC_ENC;
                        end
                        CMD_NOTE: begin
                            if (!fifo_empty) begin
                                load_byte <= fifo_data[3*DW-1:2*DW];
                                pkt_q     <= fifo_data[2*DW-1:0];
                                rem_q     <= CW'(2);
                                src_q     <= SRC_NOTE;
                                fifo_pop  <= 1'b1;
                            end else begin
                                load_byte <= '0;
                            end
                        end
                        default: load_byte <= '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spi_status_responder.sv
// SPI target that answers one-byte requests with peripheral status.
// Pins are oversampled by clk; MISO is released while deselected.
// Assumes: SCLK half period of at least six clk cycles.
module spi_status_responder
    import spi_resp_pkg::*;
#(
    parameter int POT_N       = 8,
    parameter int ENC_N       = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sclk,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    output logic                spi_miso_oe,
    input  logic [DW-1:0]       sw_status,
    input  logic [POT_N*DW-1:0] pot_vals,
    input  logic [ENC_N*DW-1:0] enc_vals,
    input  logic                fifo_empty,
    input  logic [3*DW-1:0]     fifo_data,
    output logic                fifo_pop
);
    logic          sclk_rise;
    logic          sclk_fall;
    logic          cs_act;
    logic          mosi_s;
    logic          byte_done;
    logic [DW-1:0] rx_byte;
    logic          load_en;
    logic [DW-1:0] load_byte;
    logic          miso_bit;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spi_byte_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .load_en   (load_en),
        .load_byte (load_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso_bit  (miso_bit)
    );

    spi_reply_seq #(.POT_N(POT_N), .ENC_N(ENC_N)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .sw_status  (sw_status),
        .pot_vals   (pot_vals),
        .enc_vals   (enc_vals),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .load_en    (load_en),
        .load_byte  (load_byte),
        .fifo_pop   (fifo_pop)
    );

    assign spi_miso_oe = cs_act;
    assign spi_miso    = cs_act ? miso_bit : 1'bz;
endmodule

// File: rtl/spi_status_responder_chk.sv
// Temporal checks on the responder's ports and internal handoffs.
// Assumes: bound to spi_status_responder with its internal strobes visible.
module spi_status_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso_oe,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic byte_done,
    input logic load_en
);
    // R2: three sampled cycles of deselect leave MISO undriven.
    p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe);

    // R1: every completed byte while selected yields a transmit load.
    p_load_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && spi_miso_oe) |=> load_en);

    // R1: loads only follow a completed byte.
    p_load_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> $past(byte_done));

    // R11: pop strobe is one cycle wide.
    p_pop_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R7: no pop from an empty FIFO.
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> $past(!fifo_empty));

    // R6: a pop coincides with loading the packet's status byte.
    p_pop_with_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> load_en);
endmodule

bind spi_status_responder spi_status_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .fifo_empty  (fifo_empty),
    .fifo_pop    (fifo_pop),
    .byte_done   (byte_done),
    .load_en     (load_en)
);

// File: tb/spi_status_responder_bench.sv
module spi_status_responder_bench;
    localparam int POT_N = 8;
    localparam int ENC_N = 19;
    localparam int HALF  = 8;
    localparam int ROWS  = 8;

    localparam logic [7:0] ROW_CMD [ROWS] = '{8'h01, 8'h02, 8'h03, 8'h04,
                                               8'h04, 8'h04, 8'h09, 8'h00};
    localparam int ROW_LEN [ROWS] = '{1, POT_N, ENC_N, 3, 3, 1, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    wire  miso;
    wire  miso_oe;
    wire  fifo_pop;
    logic [7:0] sw;
    logic [POT_N*8-1:0] pots;
    logic [ENC_N*8-1:0] encs;
    logic [23:0] pkts [4];
    int fill_n = 0;
    int pop_n = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    wire fifo_empty = (pop_n >= fill_n);
    wire [23:0] fifo_data = pkts[pop_n % 4];

    always #5 clk = ~clk;

    always @(negedge clk) if (fifo_pop) pop_n = pop_n + 1;

    spi_status_responder #(.POT_N(POT_N), .ENC_N(ENC_N)) u_spi_status_responder (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .sw_status(sw), .pot_vals(pots), .enc_vals(encs),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks nbits of tx out MSB first, capturing MISO at each rising edge.
    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b > 7 - nbits; b--) begin
            mosi = tx[b];
            wait_clk(HALF);
            sclk = 1'b1;
            rx[b] = miso;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    function automatic logic [7:0] expect_byte(input logic [7:0] cmd, input int k,
                                               input logic [23:0] pkt, input bit avail);
        case (cmd)
            8'h01: return sw;
            8'h02: return pots[k*8 +: 8];
            8'h03: return encs[k*8 +: 8];
            8'h04: return avail ? pkt[23 - k*8 -: 8] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] cmd, input bit avail);
        case (cmd)
            8'h01: return "R3";
            8'h02: return "R4";
            8'h03: return "R5";
            8'h04: return avail ? "R6" : "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        sw = 8'hA5;
        for (int i = 0; i < POT_N; i++) pots[i*8 +: 8] = 8'(8'h10 + i);
        for (int i = 0; i < ENC_N; i++) encs[i*8 +: 8] = 8'(8'h40 + 3 * i);
        pkts[0] = 24'h90_3C_64;
        pkts[1] = 24'h80_3E_20;
        pkts[2] = 24'h0;
        pkts[3] = 24'h0;
        fill_n = 2;
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(6);

        // Reset state: deselected output released, no pop.
        check("R2 oe low while deselected", int'(miso_oe), 0);
        check("R11 no pop after reset", pop_n, 0);

        // Vector table walk: each row is one transaction.
        for (int r = 0; r < ROWS; r++) begin
            logic [23:0] pkt;
            bit avail;
            int pops0;
            pkt = fifo_data;
            avail = !fifo_empty;
            pops0 = pop_n;
            cs_n = 1'b0;
            wait_clk(HALF);
            check("R2 oe high while selected", int'(miso_oe), 1);
            xfer(ROW_CMD[r], 8, rx);
            check("R1 first byte is zero", int'(rx), 0);
            for (int k = 0; k < ROW_LEN[r]; k++) begin
                // Filler 0x01 would switch the stream if wrongly decoded (R9).
                xfer((k == ROW_LEN[r] - 1) ? 8'h00 : 8'h01, 8, rx);
                check(tag_for(ROW_CMD[r], avail), int'(rx),
                      int'(expect_byte(ROW_CMD[r], k, pkt, avail)));
            end
            xfer(8'h05, 8, rx);
            check("R9 byte during last reply decoded", int'(rx), 0);
            cs_n = 1'b1;
            wait_clk(2 * HALF);
            check((ROW_CMD[r] == 8'h04) ? "R11 pop count" : "R7 no pop",
                  pop_n - pops0, (ROW_CMD[r] == 8'h04 && avail) ? 1 : 0);
        end
        check("R2 oe low after deselect", int'(miso_oe), 0);

        // R10: abort in the middle of an encoder reply.
        cs_n = 1'b0;
        wait_clk(HALF);
        xfer(8'h03, 8, rx);
        xfer(8'h01, 8, rx);
        check("R5 encoder entry 0 before abort", int'(rx), int'(encs[7:0]));
        xfer(8'h01, 8, rx);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
        xfer(8'h02, 8, rx);
        check("R10 first byte after abort is zero", int'(rx), 0);
        xfer(8'h01, 8, rx);
        check("R10 request decoded after abort", int'(rx), int'(pots[7:0]));
        cs_n = 1'b1;
        wait_clk(2 * HALF);

        // R10: partial byte discarded on deselect.
        cs_n = 1'b0;
        wait_clk(HALF);
        xfer(8'hFF, 5, rx);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
        xfer(8'h01, 8, rx);
        xfer(8'h01, 8, rx);
        check("R10 partial byte discarded", int'(rx), int'(sw));
        // R3 and R9: single-byte reply leaves next byte decoded at once.
        xfer(8'h00, 8, rx);
        check("R3 switch reply repeats back to back", int'(rx), int'(sw));
        xfer(8'h00, 8, rx);
        check("R8 unknown request gives zero", int'(rx), 0);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        check("R7 no pop from empty FIFO", pop_n, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule